// File: doc/BRIEF.md
# Down-Counting Timer with Watchdog Mode

This block is a down-counter driven by a tick derived from the system clock. The clock is first divided by a fixed factor (four by default). It is then divided again by a programmable prescaler, where a prescaler value `p` gives a divide ratio of `p+1`. The counter has two uses. As a general-purpose timer it can be started and stopped, and it runs in either single-shot or continuous reload mode. Each time it reaches end of count it raises a one-cycle interrupt pulse.

The block can instead be locked into watchdog mode. In this mode it counts whatever the start/stop bit holds. Software cannot turn it off and can change only the prescaler. When it reaches end of count it emits a one-cycle system-reset pulse. Software prevents the reset by writing a two-byte service sequence to a key register. An input pin can force watchdog mode straight out of reset.

Software reaches the block through a small register bus with one write per cycle and combinational read data. Register map, selected by `bus_addr`:
- 0: control. Bit 0 is run, bit 1 is continuous, bit 2 is the active-low watchdog enable.
- 1: prescaler value.
- 2: a write sets the reload constant; a read returns the live counter.
- 4: service key, write only.

Every other address reads as zero.

Top module: `tmw_timer`

## Requirements
- R1: Out of reset the counter reads all ones, the prescaler reads all ones, control reads 0b100 (stopped, single mode, watchdog off), and `irq` and `wdg_rst` are low.
- R2: One count tick occurs every DIV*(p+1) clock cycles. A constant `c` loaded at start reaches end of count DIV*(p+1)*(c+1) cycles after the write that sets run. In timer mode, end of count drives `irq` high for exactly one cycle.
- R3: Writing run=0 freezes the counter. Setting run again, with no constant written in between, resumes from the frozen value `v`, and end of count follows after DIV*(p+1)*(v+1) cycles.
- R4: A constant written while the counter is running does not disturb the current period. It is loaded at the next end of count.
- R5: A prescaler write takes effect from the very next divided-clock tick.
- R6: In single mode, end of count clears the run bit and leaves the counter holding the reload constant.
- R7: A constant written while the counter is stopped is loaded when run is next set.
- R8: In continuous mode, end of count reloads the constant and counting continues with run still set. Successive `irq` pulses are DIV*(p+1)*(c+1) cycles apart.
- R9: Writing 0 to control bit 2 enters watchdog mode. This loads the constant and starts counting even with run=0. Bit 2 then stays 0 whatever is written.
- R10: In watchdog mode, writes to the control register and to the reload constant are ignored. Prescaler writes still take effect.
- R11: In watchdog mode, end of count gives a one-cycle `wdg_rst` pulse and no `irq`. The counter then reloads and keeps counting.
- R12: In watchdog mode, writing 0xAA and then 0x55 to the key register reloads the counter and restarts the divider. Any other value written in between aborts the sequence, and so does a 0x55 not preceded by 0xAA.
- R13: While `hw_wdg_en` is high, the block enters watchdog mode at the next clock edge, using the reset-value constant and prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_wdg_en | input | 1 | Forces watchdog mode when high |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | One-cycle end-of-count pulse in timer mode |
| wdg_rst | output | 1 | One-cycle system-reset pulse in watchdog mode |

## Verification
The bench builds the block with an 8-bit counter, a 2-bit prescaler and the default divide-by-four. This keeps every period down to a few hundred cycles. It can therefore sweep all four prescaler values against eight reload constants and compare each measured end-of-count latency with DIV*(p+1)*(c+1). The small widths also make the reset-value watchdog period (4096 cycles) short enough to check exactly for the hardware-forced case. Freeze/resume, shadowed reloads, immediate prescaler changes and the key sequence are each timed against edge counts derived from the requirements.

// File: rtl/tmw_pkg.sv
package tmw_pkg;
  // Register addresses
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_PRE  = 3'd1;
  localparam logic [2:0] ADDR_LOAD = 3'd2;
  localparam logic [2:0] ADDR_KEY  = 3'd4;

  // Control register bit positions
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_CONT = 1;
  localparam int CTRL_WDN  = 2;

  // Service key values
  localparam logic [7:0] KEY_ARM  = 8'hAA;
  localparam logic [7:0] KEY_FIRE = 8'h55;
endpackage

// File: rtl/tmw_tick.sv
module tmw_tick #(
  parameter int PRE_W = 8,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic             base;
  logic             pre_hit;

  assign base    = active && (div_q == DIV_LAST);
  assign pre_hit = (pcnt_q >= pre);   // a lowered prescaler still fires at once
  assign tick    = base && pre_hit && !restart;

  always_comb begin
    div_d  = div_q;
    pcnt_d = pcnt_q;
    if (restart || !active) begin
      div_d  = '0;
      pcnt_d = '0;
    end else begin
      div_d = base ? '0 : div_q + 1'b1;
      if (base) pcnt_d = pre_hit ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pcnt_q <= '0;
    end else begin
      div_q  <= div_d;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/tmw_service.sv
module tmw_service
  import tmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       fire
);
  logic armed_q, armed_d;

  assign fire = enable && key_wr && armed_q && (key_data == KEY_FIRE);

  always_comb begin
    armed_d = armed_q;
    if (key_wr) armed_d = (key_data == KEY_ARM);
    if (!enable) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/tmw_count.sv
module tmw_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wdg_mode,
  input  logic             wdg_enter,
  input  logic             svc_fire,
  input  logic             ctrl_wr,
  input  logic             run_wdata,
  input  logic             cont,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             active,
  output logic             eoc
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             pend_q, pend_d;
  logic             start;

  assign active = run_q || wdg_mode;
  assign eoc    = tick && (cnt_q == '0);
  assign start  = ctrl_wr && run_wdata && !run_q && !wdg_mode;

  always_comb begin
    cnt_d = cnt_q;
    if (wdg_enter || svc_fire)   cnt_d = load_val;
    else if (tick)               cnt_d = eoc ? load_val : cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
    else if (start && pend_q)    cnt_d = load_val;
  end

  always_comb begin
    pend_d = pend_q;
    if (load_wr) pend_d = 1'b1;
    else if (eoc || wdg_enter || svc_fire || start) pend_d = 1'b0;
  end

  always_comb begin
    run_d = run_q;
    if (ctrl_wr)                          run_d = run_wdata;
    else if (eoc && !cont && !wdg_mode)   run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      pend_q <= pend_d;
    end
  end

  assign cnt = cnt_q;
  assign run = run_q;
endmodule

// File: rtl/tmw_timer.sv
module tmw_timer
  import tmw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_wdg_en,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq,
  output logic             wdg_rst
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic             cont_q, cont_d;
  logic             wdg_en_n_q, wdg_en_n_d;
  logic             irq_q, irq_d, rst_q, rst_d;

  logic             wdg_mode, wdg_enter;
  logic             ctrl_wr, load_wr, pre_wr, key_wr;
  logic             svc_fire, tick, eoc, active, run;
  logic [CNT_W-1:0] cnt;

  assign wdg_mode = !wdg_en_n_q;
  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL) && !wdg_mode;
  assign load_wr  = bus_wr && (bus_addr == ADDR_LOAD) && !wdg_mode;
  assign pre_wr   = bus_wr && (bus_addr == ADDR_PRE);
  assign key_wr   = bus_wr && (bus_addr == ADDR_KEY);

  always_comb begin
    pre_d      = pre_wr  ? bus_wdata[PRE_W-1:0] : pre_q;
    load_d     = load_wr ? bus_wdata : load_q;
    cont_d     = ctrl_wr ? bus_wdata[CTRL_CONT] : cont_q;
    wdg_en_n_d = wdg_en_n_q && !hw_wdg_en && !(ctrl_wr && !bus_wdata[CTRL_WDN]);
    wdg_enter  = wdg_en_n_q && !wdg_en_n_d;
    irq_d      = eoc && !wdg_mode;
    rst_d      = eoc && wdg_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '1;
      load_q     <= '1;
      cont_q     <= 1'b0;
      wdg_en_n_q <= 1'b1;
      irq_q      <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      pre_q      <= pre_d;
      load_q     <= load_d;
      cont_q     <= cont_d;
      wdg_en_n_q <= wdg_en_n_d;
      irq_q      <= irq_d;
      rst_q      <= rst_d;
    end
  end

  tmw_tick #(.PRE_W(PRE_W), .DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .active(active),
    .restart(wdg_enter || svc_fire), .pre(pre_q), .tick(tick)
  );

  tmw_service u_svc (
    .clk(clk), .rst_n(rst_n), .enable(wdg_mode), .key_wr(key_wr),
    .key_data(bus_wdata[7:0]), .fire(svc_fire)
  );

  tmw_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wdg_mode(wdg_mode),
    .wdg_enter(wdg_enter), .svc_fire(svc_fire), .ctrl_wr(ctrl_wr),
    .run_wdata(bus_wdata[CTRL_RUN]), .cont(cont_q), .load_wr(load_wr),
    .load_val(load_q), .cnt(cnt), .run(run), .active(active), .eoc(eoc)
  );

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = CNT_W'({wdg_en_n_q, cont_q, run});
      ADDR_PRE:  bus_rdata = CNT_W'(pre_q);
      ADDR_LOAD: bus_rdata = cnt;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq     = irq_q;
  assign wdg_rst = rst_q;
endmodule

// File: rtl/tmw_checker.sv
module tmw_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             wdg_rst,
  input logic             run,
  input logic             cont,
  input logic             wdg_en_n,
  input logic [CNT_W-1:0] cnt,
  input logic             bus_wr,
  input logic             hw_wdg_en
);
  // R2: interrupt is a single-cycle pulse
  a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R11: reset request is a single-cycle pulse
  a_r11_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |=> !wdg_rst);

  // R11: reset request only in watchdog mode, never together with irq
  a_r11_rst_in_wdg: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |-> (!wdg_en_n && !irq));

  // R9: watchdog mode cannot be left
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wdg_en_n |=> !wdg_en_n);

  // R3: a stopped timer holds its count when nothing is written
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wdg_en_n && !bus_wr && !hw_wdg_en) |=> $stable(cnt));

  // R6: single-mode end of count leaves run cleared
  a_r6_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cont && !$past(bus_wr)) |-> !run);
endmodule

bind tmw_timer tmw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .wdg_rst(wdg_rst), .run(run),
  .cont(cont_q), .wdg_en_n(wdg_en_n_q), .cnt(cnt), .bus_wr(bus_wr),
  .hw_wdg_en(hw_wdg_en)
);

// File: tb/tmw_timer_test.sv
module tmw_timer_test;
  localparam int CW = 8, PW = 2, DV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_wdg_en = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          irq, wdg_rst;

  int cyc = 0, checks = 0, errors = 0, irq_seen = 0;

  tmw_timer #(.CNT_W(CW), .PRE_W(PW), .DIV(DV)) uut (
    .clk(clk), .rst_n(rst_n), .hw_wdg_en(hw_wdg_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdg_rst(wdg_rst)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (irq) irq_seen <= irq_seen + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    e = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_ev(input bit use_rst, output int t);
    t = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (use_rst ? wdg_rst : irq) begin t = cyc; break; end
    end
    if (t < 0) chk(1'b0, "watchdog timeout", 0, 1);
  endtask

  initial begin
    int e, t, t1, t2, t3, v1, v2, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v1); chk(v1 == 4, "R1 ctrl", v1, 4);
    rd(3'd1, v1); chk(v1 == 3, "R1 prescaler", v1, 3);
    rd(3'd2, v1); chk(v1 == 255, "R1 counter", v1, 255);
    chk(!irq && !wdg_rst, "R1 outputs", int'(irq) + int'(wdg_rst), 0);

    // R2/R6/R7 sweep over prescaler and constant, single mode
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 8; c++) begin
        wr(3'd1, 8'(p), e);
        wr(3'd2, 8'(c), e);
        wr(3'd0, 8'h05, e);
        wait_ev(1'b0, t);
        chk(t - e == DV*(p+1)*(c+1), "R2 latency", t - e, DV*(p+1)*(c+1));
        @(negedge clk);
        chk(!irq, "R2 pulse width", int'(irq), 0);
        rd(3'd0, v1); chk(v1 == 4, "R6 run cleared", v1, 4);
        rd(3'd2, v1); chk(v1 == c, "R6 reloaded", v1, c);
      end

    // R3 freeze and resume
    wr(3'd1, 8'd0, e); wr(3'd2, 8'd200, e); wr(3'd0, 8'h05, e);
    repeat (41) @(negedge clk);
    wr(3'd0, 8'h04, e);
    rd(3'd2, v1);
    repeat (30) @(negedge clk);
    rd(3'd2, v2);
    chk(v1 == v2 && v1 < 200, "R3 frozen", v2, v1);
    wr(3'd0, 8'h05, e); wait_ev(1'b0, t);
    chk(t - e == DV*(v1+1), "R3 resume", t - e, DV*(v1+1));

    // R7 constant written while stopped
    wr(3'd0, 8'h05, e);
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h04, e); wr(3'd2, 8'd3, e); wr(3'd0, 8'h05, e);
    wait_ev(1'b0, t);
    chk(t - e == 16, "R7 load at start", t - e, 16);

    // R8 continuous, R4 shadowed constant
    wr(3'd2, 8'd5, e); wr(3'd0, 8'h07, e);
    wait_ev(1'b0, t1); chk(t1 - e == 24, "R8 first period", t1 - e, 24);
    wait_ev(1'b0, t2); chk(t2 - t1 == 24, "R8 repeat period", t2 - t1, 24);
    wr(3'd2, 8'd2, e);
    wait_ev(1'b0, t3); chk(t3 - t2 == 24, "R4 period unchanged", t3 - t2, 24);
    wait_ev(1'b0, t);  chk(t - t3 == 12, "R4 new constant", t - t3, 12);
    rd(3'd0, v1); chk(v1 == 7, "R8 run kept", v1, 7);

    // R5 immediate prescaler
    wr(3'd0, 8'h06, e); wr(3'd1, 8'd3, e); wr(3'd2, 8'd0, e); wr(3'd0, 8'h07, e);
    wait_ev(1'b0, t1); chk(t1 - e == 16, "R5 slow period", t1 - e, 16);
    wr(3'd1, 8'd0, e);
    wait_ev(1'b0, t2); chk(t2 - t1 == 4, "R5 immediate", t2 - t1, 4);
    wr(3'd0, 8'h04, e);

    // R9 watchdog entry, R10/R11 behaviour
    wr(3'd2, 8'd6, e);
    d = irq_seen;
    wr(3'd0, 8'h00, e);
    wait_ev(1'b1, t1); chk(t1 - e == 28, "R9 entry count", t1 - e, 28);
    @(negedge clk); chk(!wdg_rst, "R11 pulse width", int'(wdg_rst), 0);
    wr(3'd0, 8'h07, e);
    rd(3'd0, v1); chk(v1 == 0, "R9 bit locked / R10 ctrl ignored", v1, 0);
    wait_ev(1'b1, t2); chk(t2 - t1 == 28, "R11 reload period", t2 - t1, 28);
    wr(3'd2, 8'd1, e);
    wait_ev(1'b1, t3); chk(t3 - t2 == 28, "R10 constant ignored", t3 - t2, 28);
    wr(3'd1, 8'd1, e);
    wait_ev(1'b1, t); chk(t - t3 == 56, "R10 prescaler applied", t - t3, 56);
    chk(irq_seen == d, "R11 no irq", irq_seen - d, 0);

    // R12 service sequence
    wr(3'd4, 8'hAA, e); wr(3'd4, 8'h55, e);
    wait_ev(1'b1, t1); chk(t1 - e == 56, "R12 refresh", t1 - e, 56);
    wr(3'd4, 8'hAA, e); wr(3'd4, 8'h12, e); wr(3'd4, 8'h55, e);
    wait_ev(1'b1, t2); chk(t2 - t1 == 56, "R12 aborted", t2 - t1, 56);
    wr(3'd4, 8'h55, e);
    wait_ev(1'b1, t3); chk(t3 - t2 == 56, "R12 lone fire", t3 - t2, 56);

    // R13 hardware-forced watchdog
    @(negedge clk); rst_n = 1'b0; hw_wdg_en = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); e = cyc;
    rd(3'd0, v1); chk(v1 == 0, "R13 forced mode", v1, 0);
    wait_ev(1'b1, t); chk(t - e == 4096, "R13 reset-value period", t - e, 4096);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule